// File: doc/BRIEF.md
# Self-Supply and Fault State Manager

This block supervises the supply of an offline switching controller that charges its own supply capacitor from the high-voltage rail. It receives four digitized comparisons of the supply voltage (above 12 V, above 10 V, above 5.3 V and above 4 V). It also receives an overload flag, a single-cycle overvoltage pulse, an external latch request and a thermal flag. From these it decides three things: when the high-voltage charge source runs, when the power switch may be driven, and when the rest of the chip should drop to low consumption. It also emits a one-cycle pulse that starts the soft-start ramp.

In normal running, the supply capacitor swings between 10 V and 12 V. The falling part of that swing also serves as the overload timer. If the feedback still reports overload when the supply reaches 10 V, the block stops switching and lets the supply drain down to 5.3 V. It then restarts from scratch. An overvoltage event or an external request latches the block off until the supply is removed. The supply comparisons are resynchronized on entry, and the block acts only on their crossings, never on their levels.

Top module: `supply_fault_mgr`

## Requirements
- R1: While reset is held and after its release, the charge source is on, switching is off, standby is low and no soft-start pulse is present.
- R2: From startup, switching stays off until the above-12 V input rises. That rise is acted on three clock cycles after the input changes (two synchronizer flops plus one edge register). At that point the charge source turns off, switching turns on and one soft-start pulse is issued.
- R3: While running, a falling crossing of 10 V without overload turns the charge source on. A rising crossing of 12 V turns it off without a soft-start pulse. Switching stays on throughout.
- R4: If overload is high at the 10 V falling crossing, switching stops, the charge source stays off and standby goes high. This state holds until 5.3 V is crossed.
- R5: In overload wait, a falling crossing of 5.3 V clears standby and turns the charge source on with switching off. The next rising crossing of 12 V restarts switching with a soft-start pulse.
- R6: An overload that clears before the 10 V falling crossing causes no latch-off.
- R7: An overvoltage pulse, or a high external latch request, stops switching from the next clock cycle. Standby stays low.
- R8: While latched, the charge source turns off on each rising crossing of 12 V and on on each falling crossing of 5.3 V. Switching stays off.
- R9: The latch clears only on a falling crossing of 4 V while no latch request is present. It then returns to startup (charge on, switching off).
- R10: Every soft-start pulse lasts exactly one cycle. A pulse comes only from leaving startup or from a thermal release while running.
- R11: While the thermal flag is high, switching is off from the next cycle. Its release while running restores switching and issues a soft-start pulse in the next cycle.
- R12: A falling crossing of 4 V from any unlatched state returns to startup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_gt_run_i | input | 1 | Supply above 12 V |
| vcc_gt_rearm_i | input | 1 | Supply above 10 V |
| vcc_gt_restart_i | input | 1 | Supply above 5.3 V |
| vcc_gt_clear_i | input | 1 | Supply above 4 V |
| overload_i | input | 1 | Feedback at its maximum (overload) |
| ovp_pulse_i | input | 1 | One-cycle overvoltage detection |
| ext_latch_i | input | 1 | External latch-off request |
| thermal_i | input | 1 | Over-temperature flag |
| charge_en_o | output | 1 | High-voltage charge source enable |
| switch_en_o | output | 1 | Power switch drive enable |
| standby_o | output | 1 | Low-consumption request |
| softstart_o | output | 1 | One-cycle soft-start trigger |

## Verification
The assertions assume the four supply inputs describe one physical voltage. That means they are nested (above 12 V implies above 10 V and so on), and each crossing is held far longer than the synchronizer latency. They also assume the overvoltage input is a single-cycle pulse, and that the overload, thermal and latch inputs are already synchronous. The random phase guarantees these by driving all four compares from one simulated supply level. That level moves by less than the smallest gap between thresholds and is held for six cycles per step. It rises when the expected charge source is on and falls otherwise, apart from occasional forced unplug periods. Each step changes at most one of the flag inputs.

// File: rtl/supply_fault_mgr.sv
module supply_fault_mgr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_gt_run_i,
  input  logic vcc_gt_rearm_i,
  input  logic vcc_gt_restart_i,
  input  logic vcc_gt_clear_i,
  input  logic overload_i,
  input  logic ovp_pulse_i,
  input  logic ext_latch_i,
  input  logic thermal_i,
  output logic charge_en_o,
  output logic switch_en_o,
  output logic standby_o,
  output logic softstart_o
);

  localparam int NLVL = 4;

  typedef enum logic [2:0] {
    ST_BOOT, ST_RUN_CHG, ST_RUN_DIS, ST_OL_WAIT, ST_LATCH
  } state_t;

  logic [NLVL-1:0] sync_q [SYNC_STAGES];
  logic [NLVL-1:0] lvl, lvl_q;
  state_t state, nxt;
  logic lat_chg, nxt_lat, therm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      lvl_q <= '0;
    end else begin
      sync_q[0] <= {vcc_gt_clear_i, vcc_gt_restart_i, vcc_gt_rearm_i, vcc_gt_run_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      lvl_q <= lvl;
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  wire rise_run  =  lvl[0] & ~lvl_q[0];
  wire fall_arm  = ~lvl[1] &  lvl_q[1];
  wire fall_rst  = ~lvl[2] &  lvl_q[2];
  wire fall_clr  = ~lvl[3] &  lvl_q[3];
  wire latch_req = ovp_pulse_i | ext_latch_i;
  wire running   = (state == ST_RUN_CHG) | (state == ST_RUN_DIS);

  always_comb begin
    nxt = state;
    nxt_lat = lat_chg;
    if (state == ST_LATCH) begin
      if (fall_clr && !latch_req) nxt = ST_BOOT;
      else if (rise_run)          nxt_lat = 1'b0;
      else if (fall_rst)          nxt_lat = 1'b1;
    end else if (latch_req) begin
      nxt = ST_LATCH;
      nxt_lat = charge_en_o;
    end else if (fall_clr) begin
      nxt = ST_BOOT;
    end else begin
      case (state)
        ST_BOOT:    if (rise_run) nxt = ST_RUN_DIS;
        ST_RUN_DIS: if (fall_arm) nxt = overload_i ? ST_OL_WAIT : ST_RUN_CHG;
        ST_RUN_CHG: if (rise_run) nxt = ST_RUN_DIS;
        ST_OL_WAIT: if (fall_rst) nxt = ST_BOOT;
        default:    nxt = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_BOOT;
      lat_chg <= 1'b0;
      therm_q <= 1'b0;
      softstart_o <= 1'b0;
    end else begin
      state <= nxt;
      lat_chg <= nxt_lat;
      therm_q <= thermal_i;
      softstart_o <= ((state == ST_BOOT) && (nxt == ST_RUN_DIS)) ||
                     (running && therm_q && !thermal_i);
    end
  end

  assign charge_en_o = (state == ST_BOOT) | (state == ST_RUN_CHG) |
                       ((state == ST_LATCH) & lat_chg);
  assign switch_en_o = running & ~therm_q;
  assign standby_o   = (state == ST_OL_WAIT);

endmodule

// File: rtl/supply_fault_mgr_chk.sv
module supply_fault_mgr_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_gt_run_i,
  input logic vcc_gt_rearm_i,
  input logic vcc_gt_restart_i,
  input logic vcc_gt_clear_i,
  input logic overload_i,
  input logic ovp_pulse_i,
  input logic ext_latch_i,
  input logic thermal_i,
  input logic charge_en_o,
  input logic switch_en_o,
  input logic standby_o,
  input logic softstart_o
);

  a_r4_standby_needs_overload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_o) |-> $past(overload_i));

  a_r5_restart_charges: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby_o) && !$past(ovp_pulse_i) && !$past(ext_latch_i) |-> charge_en_o);

  a_r7_ovp_stops_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_pulse_i |=> !switch_en_o && !standby_o);

  a_r7_ext_stops_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ext_latch_i |=> !switch_en_o && !standby_o);

  a_r10_softstart_single: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_o |=> !softstart_o);

  a_r11_thermal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_i |=> !switch_en_o);

endmodule

bind supply_fault_mgr supply_fault_mgr_chk u_chk (.*);

// File: tb/supply_fault_mgr_bench.sv
module supply_fault_mgr_bench;
  logic clk = 0, rst_n = 0;
  logic v_run = 0, v_arm = 0, v_rst = 0, v_clr = 0;
  logic overload = 0, ovp = 0, ext = 0, thermal = 0;
  logic charge, sw, stby, ss;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam int B = 0, RC = 1, RD = 2, OL = 3, LA = 4;

  always #10 clk = ~clk;

  supply_fault_mgr u_supply_fault_mgr (
    .clk(clk), .rst_n(rst_n),
    .vcc_gt_run_i(v_run), .vcc_gt_rearm_i(v_arm),
    .vcc_gt_restart_i(v_rst), .vcc_gt_clear_i(v_clr),
    .overload_i(overload), .ovp_pulse_i(ovp), .ext_latch_i(ext), .thermal_i(thermal),
    .charge_en_o(charge), .switch_en_o(sw), .standby_o(stby), .softstart_o(ss));

  function automatic logic [3:0] levels(int v);
    return {v > 40, v > 53, v > 100, v > 120};
  endfunction

  function automatic bit m_charge(int st, bit lat);
    return st == B || st == RC || (st == LA && lat);
  endfunction

  task automatic set_v(int v);
    {v_clr, v_rst, v_arm, v_run} = levels(v);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, nv, st, lat, ssexp, sscnt, unplug, ev;
    bit ovp_now, th_old;
    logic [3:0] lo, ln;
    set_v(0);
    step(3);
    chk(charge, 1, "R1 charge in reset"); chk(sw, 0, "R1 switch in reset");
    rst_n = 1;
    step(2);
    chk(charge, 1, "R1 charge"); chk(sw, 0, "R1 switch");
    chk(stby, 0, "R1 standby"); chk(ss, 0, "R1 softstart");
    set_v(110); step(4); chk(sw, 0, "R2 no switch below 12V");
    set_v(125); step(2); chk(sw, 0, "R2 latency");
    step(1); chk(ss, 1, "R2 softstart"); chk(sw, 1, "R2 switch"); chk(charge, 0, "R2 charge off");
    step(1); chk(ss, 0, "R10 one cycle");
    set_v(95); step(4); chk(charge, 1, "R3 charge at 10V"); chk(sw, 1, "R3 switch");
    set_v(125); step(3); chk(ss, 0, "R3 no softstart"); step(1); chk(charge, 0, "R3 charge off");
    overload = 1; set_v(110); step(4); chk(sw, 1, "R6 still running");
    overload = 0; set_v(95); step(4); chk(charge, 1, "R6 charge"); chk(stby, 0, "R6 no latch-off");
    set_v(125); step(4);
    overload = 1; set_v(95); step(4);
    chk(stby, 1, "R4 standby"); chk(charge, 0, "R4 charge"); chk(sw, 0, "R4 switch");
    set_v(60); step(4); chk(stby, 1, "R4 holds");
    set_v(50); step(4); chk(charge, 1, "R5 charge"); chk(stby, 0, "R5 standby"); chk(sw, 0, "R5 switch");
    overload = 0; set_v(125); step(3); chk(ss, 1, "R5 softstart"); chk(sw, 1, "R5 switch");
    step(1); thermal = 1; step(1); chk(sw, 0, "R11 thermal off");
    step(3); thermal = 0; step(1); chk(ss, 1, "R11 softstart"); chk(sw, 1, "R11 resume");
    ovp = 1; step(1); ovp = 0;
    chk(sw, 0, "R7 ovp stop"); chk(stby, 0, "R7 standby"); chk(charge, 0, "R7 charge kept");
    set_v(50); step(4); chk(charge, 1, "R8 charge at 5.3V");
    set_v(125); step(4); chk(charge, 0, "R8 charge off 12V"); chk(sw, 0, "R8 switch");
    set_v(95); step(4); chk(sw, 0, "R9 latched at 10V"); chk(charge, 0, "R9 latched charge");
    set_v(45); step(4); chk(charge, 1, "R8 recharge");
    set_v(30); step(4); chk(charge, 1, "R9 boot charge"); chk(sw, 0, "R9 boot switch");
    set_v(125); step(3); chk(ss, 1, "R9 restart softstart");
    step(1); ext = 1; step(1); chk(sw, 0, "R7 ext stop");
    set_v(50); step(4); set_v(30); step(4); set_v(125); step(4);
    chk(sw, 0, "R9 held by request"); chk(charge, 0, "R9 held charge");
    ext = 0; set_v(50); step(4); set_v(30); step(4); set_v(125); step(3);
    chk(ss, 1, "R9 cleared"); step(1);
    set_v(30); step(4); chk(charge, 1, "R12 charge"); chk(sw, 0, "R12 switch"); chk(stby, 0, "R12 standby");
    set_v(125); step(3); chk(ss, 1, "R12 restart"); step(3);

    void'($urandom(1234));
    v = 125; st = RD; lat = 0; unplug = 0;
    for (int h = 0; h < 2500; h++) begin
      ev = $urandom_range(0, 39);
      ovp_now = 0;
      th_old = thermal;
      if (ev == 0) overload = ~overload;
      else if (ev == 1) thermal = ~thermal;
      else if (ev == 2) ovp_now = 1;
      else if (ev == 3 && $urandom_range(0, 2) == 0) ext = ~ext;
      else if (ev == 4 && unplug == 0) unplug = 20;
      if (unplug > 0) begin nv = v - 8; unplug--; end
      else if (m_charge(st, lat[0])) nv = v + $urandom_range(2, 8);
      else nv = v - $urandom_range(2, 8);
      if (nv < 0) nv = 0;
      if (nv > 140) nv = 140;
      ssexp = 0;
      if (th_old && !thermal && (st == RC || st == RD)) ssexp++;
      if (st != LA && (ovp_now || ext)) begin lat = m_charge(st, lat[0]); st = LA; end
      lo = levels(v); ln = levels(nv);
      if (st == LA) begin
        if (lo[3] && !ln[3] && !ext) st = B;
        else if (!lo[0] && ln[0]) lat = 0;
        else if (lo[2] && !ln[2]) lat = 1;
      end else if (lo[3] && !ln[3]) st = B;
      else begin
        case (st)
          B:  if (!lo[0] && ln[0]) begin st = RD; ssexp++; end
          RD: if (lo[1] && !ln[1]) st = overload ? OL : RC;
          RC: if (!lo[0] && ln[0]) st = RD;
          OL: if (lo[2] && !ln[2]) st = B;
          default: ;
        endcase
      end
      v = nv;
      ovp = ovp_now; set_v(v);
      sscnt = 0;
      for (int c = 0; c < 6; c++) begin
        step(1);
        ovp = 0;
        if (ss) sscnt++;
      end
      chk(charge, m_charge(st, lat[0]), "R3/R8 random charge");
      chk(sw, (st == RC || st == RD) && !thermal, "R2/R11 random switch");
      chk(stby, st == OL, "R4/R5 random standby");
      checks++;
      if (sscnt != ssexp) begin
        fails++;
        $display("FAIL R10 random softstart count: actual %0d expected %0d", sscnt, ssexp);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule